// File: doc/BRIEF.md
# Masked Auxiliary Control-Word Merger

This block sits in the transmit path of a radio link framer, between the core's control transmit table and the line encoder. On every clock it produces one 32-bit outgoing word. For each bit, the word takes the value from an auxiliary client when the client's mask bit for that position is set. Otherwise it takes the value the core's own table supplies.

The client sees the frame timing outputs: hyperframe position Z, basic frame index X and word index within the basic frame. Its data and mask must reach the block exactly two clock cycles after the timing they answer. The block delays the timing indices by two stages internally, so they line up with the client data and with the table word. The table word arrives in the same cycle as the client data.

One word position carries the sync character. This is word 0 of basic frame X = 0 in hyperframe Z = 0. The client must not write over that word. If it sets any mask bit there, the block reports a one-cycle error. It also keeps the sync byte (bits [7:0]) from the table whatever the mask says. A sticky flag records that an error has happened and is cleared only by reset.

Top module: `aux_ctrl_merge`

## Requirements
- R1: While rst_ni is low, word_o is 0, err_o is 0 and err_sticky_o is 0.
- R2: Outside the sync slot, word_o bit i equals aux_data_i bit i when aux_mask_i bit i is 1, and tbl_word_i bit i when it is 0. The result appears one clock after data, mask and table word are sampled.
- R3: The sync slot test for the data sampled at clock edge n uses the timing indices sampled at edge n-2. Indices one or three edges earlier have no effect on err_o.
- R4: The sync slot is the word with z_idx_i = 0, x_idx_i = 0 and seq_idx_i = 0. A word with any of these three non-zero is not the slot.
- R5: If data sampled in the sync slot has any aux_mask_i bit set, err_o is 1 for exactly the following cycle. There is one pulse per offending word, so back-to-back offending words give back-to-back pulses.
- R6: In the sync slot, word_o bits [7:0] equal tbl_word_i bits [7:0] regardless of the mask. Bits [31:8] follow the R2 rule.
- R7: err_sticky_o becomes 1 in the same cycle as the first err_o pulse. It stays 1 until reset.
- R8: A mask with bits set in a word that is not the sync slot never raises err_o. This includes a mask of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| z_idx_i | input | 8 | Hyperframe position of the current timing output |
| x_idx_i | input | 8 | Basic frame index within the hyperframe |
| seq_idx_i | input | 4 | Word index within the basic frame |
| tbl_word_i | input | 32 | Word from the core's control transmit table, aligned with client data |
| aux_data_i | input | 32 | Client data, two cycles behind the timing indices |
| aux_mask_i | input | 32 | Client bit mask; 1 selects the client bit |
| word_o | output | 32 | Merged outgoing word, registered |
| err_o | output | 1 | One-cycle pulse when the client masks into the sync slot |
| err_sticky_o | output | 1 | Set by any err_o pulse, cleared by reset |

## Verification
The merge is exercised with four kinds of mask: random, all zero, all one, and a single bit. The all-zero and all-one masks show that the polarity of the bit select is right. The random masks catch mixed-up operands. Slot detection is tried with each of Z, X and the word index non-zero alone, which separates a full three-index match from a partial one. A full mask is applied one, two and three cycles after the slot indices, and only the two-cycle case may raise err_o, which exposes a pipeline of the wrong depth. A full mask inside the slot confirms that the sync byte survives while the upper bits still follow the client.

// File: rtl/aux_merge_pkg.sv
package aux_merge_pkg;
  localparam int unsigned DATA_W_DEF   = 32;
  localparam int unsigned Z_W_DEF      = 8;
  localparam int unsigned X_W_DEF      = 8;
  localparam int unsigned SEQ_W_DEF    = 4;
  localparam int unsigned ALIGN_DEF    = 2;
  localparam int unsigned SYNC_LSB_DEF = 0;
  localparam int unsigned SYNC_W_DEF   = 8;

  function automatic logic bit_pick(input logic tbl_b, input logic aux_b,
                                    input logic sel_b);
    return sel_b ? aux_b : tbl_b;
  endfunction
endpackage

// File: rtl/aux_idx_pipe.sv
module aux_idx_pipe #(
  parameter int unsigned W     = 20,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] idx_i,
  output logic         vld_o,
  output logic [W-1:0] idx_o
);
  logic [DEPTH:0]        vld_q;
  logic [DEPTH:0][W-1:0] idx_q;

  assign vld_q[0] = 1'b1;
  assign idx_q[0] = idx_i;

  for (genvar s = 1; s <= DEPTH; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s] <= 1'b0;
        idx_q[s] <= '0;
      end else begin
        vld_q[s] <= vld_q[s-1];
        idx_q[s] <= idx_q[s-1];
      end
    end
  end

  assign vld_o = vld_q[DEPTH];
  assign idx_o = idx_q[DEPTH];
endmodule

// File: rtl/aux_slot_detect.sv
module aux_slot_detect #(
  parameter int unsigned Z_W   = 8,
  parameter int unsigned X_W   = 8,
  parameter int unsigned SEQ_W = 4
) (
  input  logic             vld_i,
  input  logic [Z_W-1:0]   z_i,
  input  logic [X_W-1:0]   x_i,
  input  logic [SEQ_W-1:0] seq_i,
  output logic             slot_o
);
  always_comb slot_o = vld_i && (z_i == '0) && (x_i == '0) && (seq_i == '0);
endmodule

// File: rtl/aux_bit_merge.sv
module aux_bit_merge
  import aux_merge_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SYNC_LSB = 0,
  parameter int unsigned SYNC_W   = 8
) (
  input  logic              slot_i,
  input  logic [DATA_W-1:0] tbl_i,
  input  logic [DATA_W-1:0] aux_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] word_o,
  output logic              hit_o
);
  localparam int unsigned SYNC_MSB = SYNC_LSB + SYNC_W - 1;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b >= SYNC_LSB && b <= SYNC_MSB) begin : g_prot
      // sync byte is never handed to the client inside the slot
      assign word_o[b] = bit_pick(tbl_i[b], aux_i[b], mask_i[b] & ~slot_i);
    end else begin : g_free
      assign word_o[b] = bit_pick(tbl_i[b], aux_i[b], mask_i[b]);
    end
  end

  assign hit_o = slot_i & (|mask_i);
endmodule

// File: rtl/aux_err_track.sv
module aux_err_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic err_o,
  output logic sticky_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o    <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      err_o    <= hit_i;
      sticky_o <= sticky_o | hit_i;
    end
  end
endmodule

// File: rtl/aux_ctrl_merge.sv
module aux_ctrl_merge
  import aux_merge_pkg::*;
#(
  parameter int unsigned DATA_W   = DATA_W_DEF,
  parameter int unsigned Z_W      = Z_W_DEF,
  parameter int unsigned X_W      = X_W_DEF,
  parameter int unsigned SEQ_W    = SEQ_W_DEF,
  parameter int unsigned ALIGN    = ALIGN_DEF,
  parameter int unsigned SYNC_LSB = SYNC_LSB_DEF,
  parameter int unsigned SYNC_W   = SYNC_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [Z_W-1:0]    z_idx_i,
  input  logic [X_W-1:0]    x_idx_i,
  input  logic [SEQ_W-1:0]  seq_idx_i,
  input  logic [DATA_W-1:0] tbl_word_i,
  input  logic [DATA_W-1:0] aux_data_i,
  input  logic [DATA_W-1:0] aux_mask_i,
  output logic [DATA_W-1:0] word_o,
  output logic              err_o,
  output logic              err_sticky_o
);
  localparam int unsigned IDX_W = Z_W + X_W + SEQ_W;

  logic             al_vld;
  logic [IDX_W-1:0] al_idx;
  logic             al_slot;
  logic             hit;
  logic [DATA_W-1:0] mix;

  aux_idx_pipe #(.W(IDX_W), .DEPTH(ALIGN)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  ({z_idx_i, x_idx_i, seq_idx_i}),
    .vld_o  (al_vld),
    .idx_o  (al_idx)
  );

  aux_slot_detect #(.Z_W(Z_W), .X_W(X_W), .SEQ_W(SEQ_W)) u_slot (
    .vld_i  (al_vld),
    .z_i    (al_idx[IDX_W-1 -: Z_W]),
    .x_i    (al_idx[SEQ_W +: X_W]),
    .seq_i  (al_idx[SEQ_W-1:0]),
    .slot_o (al_slot)
  );

  aux_bit_merge #(.DATA_W(DATA_W), .SYNC_LSB(SYNC_LSB), .SYNC_W(SYNC_W)) u_merge (
    .slot_i (al_slot),
    .tbl_i  (tbl_word_i),
    .aux_i  (aux_data_i),
    .mask_i (aux_mask_i),
    .word_o (mix),
    .hit_o  (hit)
  );

  aux_err_track u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .err_o    (err_o),
    .sticky_o (err_sticky_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_o <= '0;
    else         word_o <= mix;
  end
endmodule

// File: rtl/aux_ctrl_merge_chk.sv
module aux_ctrl_merge_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned Z_W      = 8,
  parameter int unsigned X_W      = 8,
  parameter int unsigned SEQ_W    = 4,
  parameter int unsigned SYNC_LSB = 0,
  parameter int unsigned SYNC_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [Z_W-1:0]    z_idx_i,
  input logic [X_W-1:0]    x_idx_i,
  input logic [SEQ_W-1:0]  seq_idx_i,
  input logic [DATA_W-1:0] tbl_word_i,
  input logic [DATA_W-1:0] aux_data_i,
  input logic [DATA_W-1:0] aux_mask_i,
  input logic [DATA_W-1:0] word_o,
  input logic              err_o,
  input logic              err_sticky_o
);
  logic [1:0] since_rst;
  logic       at_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign at_slot = (z_idx_i == '0) && (x_idx_i == '0) && (seq_idx_i == '0);

  assert_rst_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (word_o == '0 && !err_o && !err_sticky_o));

  // R3 R4 R5: pulse exactly when slot indices two cycles ahead of a non-zero mask
  assert_err_align_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) |-> (err_o == ($past(at_slot, 3) && ($past(aux_mask_i) != '0))));

  assert_merge_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && !$past(at_slot, 3)) |->
      (word_o == (($past(aux_data_i) & $past(aux_mask_i)) |
                  ($past(tbl_word_i) & ~$past(aux_mask_i)))));

  assert_sync_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && $past(at_slot, 3)) |->
      (word_o[SYNC_LSB +: SYNC_W] == $past(tbl_word_i[SYNC_LSB +: SYNC_W])));

  assert_sticky_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> err_sticky_o);

  assert_sticky_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 2'd0 && $past(err_sticky_o)) |-> err_sticky_o);
endmodule

bind aux_ctrl_merge aux_ctrl_merge_chk #(
  .DATA_W(DATA_W), .Z_W(Z_W), .X_W(X_W), .SEQ_W(SEQ_W),
  .SYNC_LSB(SYNC_LSB), .SYNC_W(SYNC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .z_idx_i(z_idx_i), .x_idx_i(x_idx_i),
  .seq_idx_i(seq_idx_i), .tbl_word_i(tbl_word_i), .aux_data_i(aux_data_i),
  .aux_mask_i(aux_mask_i), .word_o(word_o), .err_o(err_o),
  .err_sticky_o(err_sticky_o)
);

// File: tb/aux_ctrl_merge_bench.sv
module aux_ctrl_merge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [7:0]  z_i = 8'd5, x_i = 8'd5;
  logic [3:0]  s_i = 4'd1;
  logic [31:0] t_i = '0, d_i = '0, m_i = '0;
  logic [31:0] word;
  logic        err, sticky;

  int checks = 0, fails = 0, err_seen = 0;
  bit done = 0;
  string ph = "R1 reset";

  always #5 clk = ~clk;

  aux_ctrl_merge u_aux_ctrl_merge (
    .clk_i(clk), .rst_ni(rst_n), .z_idx_i(z_i), .x_idx_i(x_i), .seq_idx_i(s_i),
    .tbl_word_i(t_i), .aux_data_i(d_i), .aux_mask_i(m_i),
    .word_o(word), .err_o(err), .err_sticky_o(sticky)
  );

  // reference model: queue of slot flags, one per sampled edge
  bit          slot_q[$];
  logic [31:0] e_word = '0;
  logic        e_err = 0, e_sticky = 0, e_slot = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q.delete();
      e_word = '0; e_err = 0; e_sticky = 0; e_slot = 0;
    end else begin
      slot_q.push_back(z_i == 0 && x_i == 0 && s_i == 0);
      if (slot_q.size() > 3) void'(slot_q.pop_front());
      e_slot = (slot_q.size() == 3) ? slot_q[0] : 1'b0;
      e_word = (d_i & m_i) | (t_i & ~m_i);
      if (e_slot) e_word[7:0] = t_i[7:0];
      e_err = e_slot && (m_i != 0);
      if (e_err) e_sticky = 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%h expected=%h at %0t", req, ph, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check(e_slot ? "R6 word" : "R2 word", word, e_word);
    check("R5 err", {31'd0, err}, {31'd0, e_err});
    check("R7 sticky", {31'd0, sticky}, {31'd0, e_sticky});
    if (err) err_seen++;
  end

  task automatic drive(input logic [7:0] z, input logic [7:0] x, input logic [3:0] s,
                       input logic [31:0] t, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk); #1;
    z_i = z; x_i = x; s_i = s; t_i = t; d_i = d; m_i = m;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(8'd7, 8'd9, 4'd2, $urandom, $urandom, 32'd0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2 rst_n = 1'b0;
    ph = "R1 reset";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    ph = "R2 R8 random masks off slot";
    for (int k = 0; k < 40; k++)
      drive(8'd1 + 8'(k % 3), 8'(k), 4'(k), $urandom, $urandom, $urandom);
    ph = "R2 R8 all-ones and all-zero masks";
    drive(8'd3, 8'd0, 4'd0, 32'hA5A5_5A5A, 32'h1234_5678, 32'hFFFF_FFFF);
    drive(8'd3, 8'd0, 4'd0, 32'hA5A5_5A5A, 32'h1234_5678, 32'h0000_0000);
    drive(8'd3, 8'd0, 4'd0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0100);
    idle(3);
    checks++;
    if (err_seen != 0 || sticky) begin
      fails++;
      $display("FAIL R8 no error off slot actual=%0d expected=0", err_seen);
    end

    ph = "R4 partial slot matches";
    drive(8'd0, 8'd0, 4'd1, 32'hBC, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    drive(8'd0, 8'd1, 4'd0, 32'hBC, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    drive(8'd1, 8'd0, 4'd0, 32'hBC, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    idle(4);

    ph = "R5 slot with zero mask";
    drive(8'd0, 8'd0, 4'd0, 32'h0000_00BC, $urandom, 32'd0);
    idle(4);
    checks++;
    if (err_seen != 0) begin
      fails++;
      $display("FAIL R4 R5 partial or clean slot raised error actual=%0d expected=0", err_seen);
    end

    ph = "R3 mask one cycle late of slot idx";
    drive(8'd0, 8'd0, 4'd0, 32'hBC, 32'd0, 32'd0);
    drive(8'd4, 8'd4, 4'd4, 32'hBC, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    drive(8'd4, 8'd4, 4'd4, 32'hBC, 32'hFFFF_FFFF, 32'd0);
    idle(4);
    ph = "R3 mask three cycles after slot idx";
    drive(8'd0, 8'd0, 4'd0, 32'hBC, 32'd0, 32'd0);
    drive(8'd4, 8'd4, 4'd4, 32'hBC, 32'd0, 32'd0);
    drive(8'd4, 8'd4, 4'd4, 32'hBC, 32'd0, 32'd0);
    drive(8'd4, 8'd4, 4'd4, 32'hBC, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    idle(4);
    checks++;
    if (err_seen != 0) begin
      fails++;
      $display("FAIL R3 misaligned mask raised error actual=%0d expected=0", err_seen);
    end

    ph = "R3 R6 aligned full mask in slot";
    drive(8'd0, 8'd0, 4'd0, 32'h0, 32'h0, 32'h0);
    drive(8'd4, 8'd4, 4'd4, 32'h0, 32'h0, 32'h0);
    drive(8'd4, 8'd4, 4'd4, 32'h1122_33BC, 32'hDEAD_BEEF, 32'hFFFF_FFFF);
    drive(8'd4, 8'd4, 4'd4, 32'h0, 32'h0, 32'h0);
    checks++;
    if (word !== 32'hDEAD_BEBC) begin
      fails++;
      $display("FAIL R6 sync byte kept actual=%h expected=DEADBEBC", word);
    end
    idle(3);
    checks++;
    if (err_seen != 1) begin
      fails++;
      $display("FAIL R5 one pulse per word actual=%0d expected=1", err_seen);
    end

    ph = "R5 back-to-back offending words";
    drive(8'd0, 8'd0, 4'd0, 32'hBC, 32'd0, 32'd0);
    drive(8'd0, 8'd0, 4'd0, 32'hBC, 32'd0, 32'd0);
    drive(8'd2, 8'd2, 4'd2, 32'hBC, 32'h0000_0001, 32'h0000_0001);
    drive(8'd2, 8'd2, 4'd2, 32'hBC, 32'h8000_0000, 32'h8000_0000);
    idle(4);
    checks++;
    if (err_seen != 3) begin
      fails++;
      $display("FAIL R5 back-to-back pulses actual=%0d expected=3", err_seen);
    end

    ph = "R7 sticky hold";
    idle(10);
    checks++;
    if (sticky !== 1'b1) begin
      fails++;
      $display("FAIL R7 sticky held actual=%b expected=1", sticky);
    end

    ph = "R1 mid-run reset";
    @(negedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    checks++;
    if (sticky !== 1'b0 || err !== 1'b0 || word !== 32'd0) begin
      fails++;
      $display("FAIL R1 reset clears actual=%h/%b/%b expected=0/0/0", word, err, sticky);
    end
    #1 rst_n = 1'b1;
    ph = "R2 after reset";
    for (int k = 0; k < 12; k++)
      drive(8'd9, 8'(k), 4'd3, $urandom, $urandom, $urandom);
    idle(2);
    finish_run();
  end

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule